// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words and reports whether the first is below, equal to or above the second. It is purely combinational. Inside, the operands are split into narrow slices. Each slice works out the relation of its own bit group. It then folds that result together with a three-wire relation arriving from the next less significant slice.

The chain runs from the least significant slice to the most significant one. The relation leaving the top slice is the relation of the whole words. With the default parameters, three 4-bit slices cover a 12-bit operand. The operand width and the slice width are both parameters, and the slice count is derived from them. When the width is not a whole number of slices, the unused high bits of the last slice are filled with zeros.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_word` is greater than `b_word`, both read as unsigned.
- R2: `eq_o` is 1 exactly when `a_word` and `b_word` are bit-for-bit identical.
- R3: `lt_o` is 1 exactly when `a_word` is less than `b_word`, both read as unsigned.
- R4: For every operand pair, exactly one of `lt_o`, `eq_o`, `gt_o` is 1.
- R5: Within a slice, the most significant bit position where the operands differ decides the relation. This holds whatever the less significant bits and the incoming relation are. The slice reports above when A has 1 there and below when A has 0 there.
- R6: A slice whose two bit groups are equal passes its incoming relation through unchanged. So when the upper slices are equal, a difference confined to a lower slice decides the result.
- R7: The least significant slice receives the relation "equal" (equal wire 1, below and above wires 0), so equal operands produce `eq_o` = 1 and the other two outputs 0.
- R8: When the operand width is not a multiple of the slice width, the missing high bits are treated as zeros, and R1 to R4 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | WIDTH (12) | First unsigned operand |
| b_word | input | WIDTH (12) | Second unsigned operand |
| lt_o | output | 1 | a_word is below b_word |
| eq_o | output | 1 | a_word equals b_word |
| gt_o | output | 1 | a_word is above b_word |

## Verification
Every time a slice is evaluated, the assertions check four things about that slice:
- a one-hot incoming relation gives a one-hot outgoing relation;
- an unequal bit group overrides the incoming relation in the direction set by native unsigned comparison;
- an equal bit group forwards the incoming relation unchanged;
- an outgoing "equal" is only raised when the slice's operands match.

Only the bench's scenarios can show that the slices are chained in the right order and that the least significant seed is "equal". They are also needed to show that zero padding is correct for odd widths. For these, the bench sweeps all pairs at two reduced widths and draws random and boundary pairs at 12 bits.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    // Relation between two operands; exactly one field is set when well formed.
    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    // Relation fed into the least significant slice.
    localparam rel_t REL_SEED = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

    // Combine a slice's own relation with the one arriving from below.
    function automatic rel_t merge_rel(input rel_t own, input rel_t below);
        rel_t r;
        r.lt = own.lt | (own.eq & below.lt);
        r.eq = own.eq & below.eq;
        r.gt = own.gt | (own.eq & below.gt);
        return r;
    endfunction

endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
    import mag_cmp_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    input  rel_t          casc_i,
    output rel_t          rel_o
);

    always_comb begin
        logic same;
        logic found;
        logic above;
        rel_t own;

        // Equality: every bit pair must match.
        same = 1'b1;
        for (int i = 0; i < SW; i++) begin
            same = same & ~(a_i[i] ^ b_i[i]);
        end

        // Magnitude: first differing bit scanning from the top decides.
        found = 1'b0;
        above = 1'b0;
        for (int i = SW - 1; i >= 0; i--) begin
            if (!found && (a_i[i] != b_i[i])) begin
                found = 1'b1;
                above = a_i[i];
            end
        end

        own.eq = same;
        own.gt = above;
        own.lt = ~(same | above);
        rel_o  = merge_rel(own, casc_i);

        // Checks next to the logic they guard.
        if ($onehot(casc_i)) begin
            p_onehot_r4: assert ($onehot(rel_o));
        end
        if (a_i > b_i) begin
            p_msb_above_r5: assert (rel_o.gt && !rel_o.lt && !rel_o.eq);
        end
        if (a_i < b_i) begin
            p_msb_below_r5: assert (rel_o.lt && !rel_o.gt && !rel_o.eq);
        end
        if (a_i == b_i) begin
            p_pass_r6: assert (rel_o == casc_i);
        end
        if (rel_o.eq) begin
            p_eq_r2: assert ((a_i == b_i) && casc_i.eq);
        end
    end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH   = 12,
    parameter int SLICE_W = 4
) (
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    output logic             lt_o,
    output logic             eq_o,
    output logic             gt_o
);

    localparam int NSLICE = (WIDTH + SLICE_W - 1) / SLICE_W;
    localparam int PW     = NSLICE * SLICE_W;

    logic [PW-1:0] a_pad;
    logic [PW-1:0] b_pad;
    rel_t          link [NSLICE+1];

    // R8: zero-extend to a whole number of slices.
    assign a_pad   = PW'(a_word);
    assign b_pad   = PW'(b_word);

    // R7: seed of the least significant slice.
    assign link[0] = REL_SEED;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        mag_cmp_slice #(.SW(SLICE_W)) u_slice (
            .a_i    (a_pad[g*SLICE_W +: SLICE_W]),
            .b_i    (b_pad[g*SLICE_W +: SLICE_W]),
            .casc_i (link[g]),
            .rel_o  (link[g+1])
        );
    end

    assign lt_o = link[NSLICE].lt;
    assign eq_o = link[NSLICE].eq;
    assign gt_o = link[NSLICE].gt;

endmodule

// File: tb/sim_mag_cmp_chain.sv
module sim_mag_cmp_chain;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Main instance: 12-bit operands in 4-bit slices.
    logic [11:0] a0, b0;
    logic lt0, eq0, gt0;
    mag_cmp_chain #(.WIDTH(12), .SLICE_W(4)) u0 (
        .a_word(a0), .b_word(b0), .lt_o(lt0), .eq_o(eq0), .gt_o(gt0));

    // Reduced width for exhaustive sweep: 6 bits in 2-bit slices.
    logic [5:0] a1, b1;
    logic lt1, eq1, gt1;
    mag_cmp_chain #(.WIDTH(6), .SLICE_W(2)) u1 (
        .a_word(a1), .b_word(b1), .lt_o(lt1), .eq_o(eq1), .gt_o(gt1));

    // Padded width: 7 bits in 3-bit slices.
    logic [6:0] a2, b2;
    logic lt2, eq2, gt2;
    mag_cmp_chain #(.WIDTH(7), .SLICE_W(3)) u2 (
        .a_word(a2), .b_word(b2), .lt_o(lt2), .eq_o(eq2), .gt_o(gt2));

    // Expected {lt,eq,gt} from the unsigned ordering.
    function automatic logic [2:0] expect_rel(input logic [31:0] a, input logic [31:0] b);
        return {a < b, a == b, a > b};
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got lt/eq/gt=%b expected %b", req, got, exp);
        end
    endtask

    // Compare one triple field by field and check one-hot.
    task automatic check_all(input string tag, input logic [2:0] got, input logic [2:0] exp);
        check({tag, " R3 lt"}, {got[2], 2'b00}, {exp[2], 2'b00});
        check({tag, " R2 eq"}, {1'b0, got[1], 1'b0}, {1'b0, exp[1], 1'b0});
        check({tag, " R1 gt"}, {2'b00, got[0]}, {2'b00, exp[0]});
        check({tag, " R4 onehot"}, {2'b00, $onehot(got)}, 3'b001);
    endtask

    task automatic apply12(input logic [11:0] a, input logic [11:0] b, input string tag);
        @(posedge clk);
        #1;
        a0 = a;
        b0 = b;
        @(negedge clk);
        check_all(tag, {lt0, eq0, gt0}, expect_rel(32'(a), 32'(b)));
    endtask

    initial begin
        a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R7: equal operands at reset-time values give eq only.
        @(negedge clk);
        check("R7 zero operands", {lt0, eq0, gt0}, 3'b010);

        // Directed corner cases.
        apply12(12'hFFF, 12'hFFF, "R7 all ones");
        check("R7 all ones", {lt0, eq0, gt0}, 3'b010);
        apply12(12'h001, 12'h000, "lsb above");
        apply12(12'h000, 12'hFFF, "min vs max");
        // R6: upper slices equal, difference only in the lowest slice.
        apply12(12'hA53, 12'hA52, "R6 low slice decides");
        check("R6 low slice above", {lt0, eq0, gt0}, 3'b001);
        apply12(12'h7C0, 12'h7C9, "R6 low slice below");
        check("R6 low slice below", {lt0, eq0, gt0}, 3'b100);
        // R5: top bit differs while lower bits point the other way.
        apply12(12'h800, 12'h7FF, "R5 msb above");
        check("R5 msb above", {lt0, eq0, gt0}, 3'b001);
        apply12(12'h0F0, 12'h10F, "R5 slice boundary below");
        check("R5 slice boundary below", {lt0, eq0, gt0}, 3'b100);
        apply12(12'h580, 12'h57F, "R5 middle slice above");

        // Random 12-bit pairs from a fixed seed.
        void'($urandom(32'h1D2C3B4A));
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] ra, rb;
            ra = 12'($urandom);
            rb = (n % 4 == 0) ? ra ^ (12'h1 << ($urandom % 12)) : 12'($urandom);
            if (n % 16 == 5) rb = ra;
            apply12(ra, rb, "random12");
        end

        // Exhaustive at 6 bits.
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                @(posedge clk);
                #1;
                a1 = 6'(x);
                b1 = 6'(y);
                @(negedge clk);
                check_all("sweep6", {lt1, eq1, gt1}, expect_rel(32'(x), 32'(y)));
            end
        end

        // R8: exhaustive at 7 bits with zero-padded top slice.
        for (int x = 0; x < 128; x++) begin
            for (int y = 0; y < 128; y++) begin
                @(posedge clk);
                #1;
                a2 = 7'(x);
                b2 = 7'(y);
                @(negedge clk);
                check("R8 padded sweep", {lt2, eq2, gt2}, expect_rel(32'(x), 32'(y)));
            end
        end

        done = 1'b1;
    end

    // Watchdog and summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done || cycles >= 190000) begin
            if (!done) begin
                checks++;
                errors++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            end
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule